// File: doc/BRIEF.md
# Handshaked Memory Request to AXI Single-Beat Bridge

This block sits between a processor's memory port and an AXI interconnect. On the processor side, each request is a byte address, a transfer size of one, two or four bytes, a direction flag, and write data already placed in its little-endian byte lanes. A request is taken when the block raises `cpu_addr_ok`. For a write, this also means the write data has been captured. Completion is reported later by a single `cpu_data_ok` pulse, and for a read the data appears on `cpu_rdata` in that same cycle.

On the AXI side, every request becomes exactly one single-beat transaction. A read is sent on the read address channel. A write is sent on the write address and write data channels, and these two may complete their handshakes in either order. The write strobe is computed from the low address bits and the size. The block holds at most one read and one write in flight.

Completions reach the processor in the order the requests were taken. The block never accepts a write while a read is open. It may accept a read while a write is open, but it withholds `m_rready` until that write's response has arrived. A read to the same 32-bit word as an open write is not issued on AXI until that write has completed.

Top module: `sram_axi_bridge`

## Requirements
- R1: Each AXI request is one beat. `m_arlen` and `m_awlen` are 0, `m_wlast` is 1, and `m_arsize`/`m_awsize` equal `{1'b0, size}`, where size 0, 1 and 2 mean 1, 2 and 4 bytes. `m_araddr`/`m_awaddr` carry the byte address unchanged.
- R2: `m_wstrb` has bit i set exactly for the bytes from lane `addr[1:0]` through lane `addr[1:0] + 2**size - 1`. This gives 0001, 0010, 0100 or 1000 for bytes, 0011 or 1100 for halfwords, and 1111 for words.
- R3: A write request is accepted (`cpu_addr_ok`=1 with `cpu_req`=1) only when no read and no write are open. The data and strobe lanes sent on W are those present at acceptance, even if `cpu_wdata` changes afterwards.
- R4: A read request is accepted only when no read is open, whether or not a write is open. `cpu_addr_ok` is 0 whenever `cpu_req` is 0.
- R5: `cpu_data_ok` pulses follow acceptance order. A read's R handshake never happens while an older write has not yet received its B response.
- R6: `cpu_data_ok` is raised in the cycle of a B handshake, or of an R handshake with `m_rlast`=1. In the read case, `cpu_rdata` equals `m_rdata`. `m_bready` is always 1.
- R7: `m_arvalid` stays low while an open write targets the same 32-bit word (address bits above bit 1) as the pending read.
- R8: Once a valid is raised on AR or W, it stays high with its payload unchanged until the matching ready is seen.
- R9: During reset, `m_arvalid`, `m_awvalid`, `m_wvalid` and `cpu_data_ok` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Request present |
| cpu_wr | input | 1 | Request is a write |
| cpu_size | input | 2 | Transfer size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| cpu_addr | input | ADDR_W | Byte address of the lowest byte accessed |
| cpu_wdata | input | DATA_W | Write data in little-endian lanes |
| cpu_addr_ok | output | 1 | Request accepted (for a write, the data is captured too) |
| cpu_data_ok | output | 1 | Oldest open request completed |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_data_ok` for a read |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_araddr | output | ADDR_W | Read address |
| m_arlen | output | 8 | Read burst length, always 0 |
| m_arsize | output | 3 | Read beat size |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_rdata | input | DATA_W | Read data |
| m_rlast | input | 1 | Last read beat |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | ADDR_W | Write address |
| m_awlen | output | 8 | Write burst length, always 0 |
| m_awsize | output | 3 | Write beat size |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write byte strobes |
| m_wlast | output | 1 | Last write beat, always 1 |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready, tied high |

## Verification
The assertions assume an AXI subordinate that obeys the protocol. It raises `m_rvalid` only for an accepted read, always with `m_rlast` set, and it raises `m_bvalid` only after both the AW and W handshakes of the open write. They also assume the processor offers only the legal address/size pairings. The bench's subordinate model keeps to this. It accepts one read at a time, returns one beat per read after a random delay, and responds to a write only once it holds both the address and the data. Its processor model draws word-aligned words, halfword-aligned halfwords and any-offset bytes, and it holds `cpu_req` until acceptance while scrambling `cpu_wdata` whenever no request is pending.

// File: rtl/sram_axi_bridge.sv
module sram_axi_bridge #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_wr,
  input  logic [1:0]        cpu_size,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_addr_ok,
  output logic              cpu_data_ok,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              m_arvalid,
  input  logic              m_arready,
  output logic [ADDR_W-1:0] m_araddr,
  output logic [7:0]        m_arlen,
  output logic [2:0]        m_arsize,
  input  logic              m_rvalid,
  output logic              m_rready,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic              m_rlast,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [ADDR_W-1:0] m_awaddr,
  output logic [7:0]        m_awlen,
  output logic [2:0]        m_awsize,
  output logic              m_wvalid,
  input  logic              m_wready,
  output logic [DATA_W-1:0] m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic              m_wlast,
  input  logic              m_bvalid,
  output logic              m_bready
);
  localparam int STRB_W = DATA_W / 8;
  localparam int LANE_W = $clog2(STRB_W);

  logic              rd_busy, ar_pend;
  logic [ADDR_W-1:0] ar_addr;
  logic [1:0]        ar_size;
  logic              wr_busy, aw_pend, w_pend;
  logic [ADDR_W-1:0] aw_addr;
  logic [1:0]        aw_size;
  logic [DATA_W-1:0] w_data;
  logic [STRB_W-1:0] w_strb;
  logic [STRB_W-1:0] req_strb;
  logic [3:0]        nbytes;

  assign nbytes = 4'd1 << cpu_size;

  always_comb begin
    req_strb = '0;
    for (int i = 0; i < STRB_W; i++)
      if (i >= int'(cpu_addr[LANE_W-1:0]) &&
          i <  int'(cpu_addr[LANE_W-1:0]) + int'(nbytes))
        req_strb[i] = 1'b1;
  end

  logic rd_take, wr_take, same_word, r_done, b_done;

  assign rd_take   = cpu_req & ~cpu_wr & ~rd_busy;
  assign wr_take   = cpu_req &  cpu_wr & ~rd_busy & ~wr_busy;
  assign same_word = ar_addr[ADDR_W-1:LANE_W] == aw_addr[ADDR_W-1:LANE_W];
  assign r_done    = m_rvalid & m_rready & m_rlast;
  assign b_done    = m_bvalid & wr_busy & ~aw_pend & ~w_pend;

  assign cpu_addr_ok = rd_take | wr_take;
  assign cpu_data_ok = r_done | b_done;
  assign cpu_rdata   = m_rdata;

  assign m_arvalid = ar_pend & ~(wr_busy & same_word);
  assign m_araddr  = ar_addr;
  assign m_arlen   = 8'd0;
  assign m_arsize  = {1'b0, ar_size};
  assign m_rready  = rd_busy & ~ar_pend & ~wr_busy;

  assign m_awvalid = aw_pend;
  assign m_awaddr  = aw_addr;
  assign m_awlen   = 8'd0;
  assign m_awsize  = {1'b0, aw_size};
  assign m_wvalid  = w_pend;
  assign m_wdata   = w_data;
  assign m_wstrb   = w_strb;
  assign m_wlast   = 1'b1;
  assign m_bready  = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_busy <= 1'b0;
      ar_pend <= 1'b0;
      ar_addr <= '0;
      ar_size <= '0;
    end else if (rd_take) begin
      rd_busy <= 1'b1;
      ar_pend <= 1'b1;
      ar_addr <= cpu_addr;
      ar_size <= cpu_size;
    end else begin
      if (m_arvalid && m_arready) ar_pend <= 1'b0;
      if (r_done)                 rd_busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_busy <= 1'b0;
      aw_pend <= 1'b0;
      w_pend  <= 1'b0;
      aw_addr <= '0;
      aw_size <= '0;
      w_data  <= '0;
      w_strb  <= '0;
    end else if (wr_take) begin
      wr_busy <= 1'b1;
      aw_pend <= 1'b1;
      w_pend  <= 1'b1;
      aw_addr <= cpu_addr;
      aw_size <= cpu_size;
      w_data  <= cpu_wdata;
      w_strb  <= req_strb;
    end else begin
      if (m_awready) aw_pend <= 1'b0;
      if (m_wready)  w_pend  <= 1'b0;
      if (b_done)    wr_busy <= 1'b0;
    end
  end
endmodule

// File: rtl/sram_axi_bridge_chk.sv
module sram_axi_bridge_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_wr,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_addr_ok,
  input logic              cpu_data_ok,
  input logic              m_arvalid,
  input logic              m_arready,
  input logic [ADDR_W-1:0] m_araddr,
  input logic              m_rvalid,
  input logic              m_rready,
  input logic              m_wvalid,
  input logic              m_wready,
  input logic [DATA_W-1:0] m_wdata,
  input logic [DATA_W/8-1:0] m_wstrb,
  input logic              m_bvalid,
  input logic              m_bready
);
  localparam int LANE_W = $clog2(DATA_W / 8);

  logic rd_o, wr_o;
  logic [ADDR_W-LANE_W-1:0] wr_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_o    <= 1'b0;
      wr_o    <= 1'b0;
      wr_word <= '0;
    end else begin
      if (cpu_addr_ok && !cpu_wr)      rd_o <= 1'b1;
      else if (m_rvalid && m_rready)   rd_o <= 1'b0;
      if (cpu_addr_ok && cpu_wr) begin
        wr_o    <= 1'b1;
        wr_word <= cpu_addr[ADDR_W-1:LANE_W];
      end else if (m_bvalid && m_bready) wr_o <= 1'b0;
    end
  end

  AST_WR_TAKEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr_ok && cpu_wr |-> !wr_o && !rd_o); // R3
  AST_RD_TAKEN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr_ok && !cpu_wr |-> !rd_o); // R4
  AST_OK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr_ok |-> cpu_req); // R4
  AST_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    m_rvalid && m_rready |-> !wr_o); // R5
  AST_DONE_HAS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_data_ok |-> rd_o || wr_o); // R6
  AST_AR_WORD_HAZARD: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid |-> !(wr_o && m_araddr[ADDR_W-1:LANE_W] == wr_word)); // R7
  AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr)); // R8
  AST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid && !m_wready |=> m_wvalid && $stable(m_wdata) && $stable(m_wstrb)); // R8
  AST_STRB_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid |-> $countones(m_wstrb) == 1 || $countones(m_wstrb) == 2 || $countones(m_wstrb) == 4); // R2
endmodule

bind sram_axi_bridge sram_axi_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
  .cpu_addr_ok(cpu_addr_ok), .cpu_data_ok(cpu_data_ok),
  .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
  .m_rvalid(m_rvalid), .m_rready(m_rready),
  .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
  .m_bvalid(m_bvalid), .m_bready(m_bready)
);

// File: tb/sram_axi_bridge_bench.sv
module sram_axi_bridge_bench;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cpu_req, cpu_wr, cpu_addr_ok, cpu_data_ok;
  logic [1:0] cpu_size;
  logic [AW-1:0] cpu_addr, m_araddr, m_awaddr;
  logic [DW-1:0] cpu_wdata, cpu_rdata, m_rdata, m_wdata;
  logic m_arvalid, m_arready, m_rvalid, m_rready, m_rlast;
  logic m_awvalid, m_awready, m_wvalid, m_wready, m_wlast, m_bvalid, m_bready;
  logic [7:0] m_arlen, m_awlen;
  logic [2:0] m_arsize, m_awsize;
  logic [3:0] m_wstrb;

  sram_axi_bridge #(.ADDR_W(AW), .DATA_W(DW)) u_sram_axi_bridge (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_size(cpu_size),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_addr_ok(cpu_addr_ok),
    .cpu_data_ok(cpu_data_ok), .cpu_rdata(cpu_rdata),
    .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr), .m_arlen(m_arlen),
    .m_arsize(m_arsize), .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata),
    .m_rlast(m_rlast), .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
    .m_awlen(m_awlen), .m_awsize(m_awsize), .m_wvalid(m_wvalid), .m_wready(m_wready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast), .m_bvalid(m_bvalid),
    .m_bready(m_bready)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] strb_of(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      2'd0:    return 4'b0001 << off;
      2'd1:    return off[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] lanes(input logic [3:0] s);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{s[i]}};
    return m;
  endfunction

  logic [31:0] refm [8];
  logic [31:0] smem [8];
  logic        q_wr  [4];
  logic [31:0] q_dat [4];
  logic [3:0]  q_msk [4];
  int qh = 0, qt = 0;

  initial begin
    bit mv, mw;
    logic [1:0] ms;
    logic [31:0] ma, md;
    bit rd_o, wr_o;
    logic [2:0] wr_wd;
    logic [1:0] rd_sz, wr_sz;
    logic [31:0] rd_ad, wr_ad, wr_dt;
    logic [3:0] wr_st;
    bit ar_have, aw_have, w_have, b_pend;
    int r_cnt, b_cnt;
    logic [31:0] r_dat, w_d;
    logic [3:0] w_s;
    logic [2:0] aw_wd;
    bit p_ar, p_w;
    logic [31:0] p_araddr, p_wd;
    logic [3:0] p_ws;
    int prq, prdy, done, idle, cyc, dir_i;

    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) begin refm[i] = 32'h0; smem[i] = 32'h0; end
    rst_n = 1'b0; cpu_req = 0; cpu_wr = 0; cpu_size = 0; cpu_addr = 0; cpu_wdata = 0;
    m_arready = 0; m_rvalid = 0; m_rdata = 0; m_rlast = 1; m_awready = 0; m_wready = 0; m_bvalid = 0;
    mv = 0; mw = 0; ms = 0; ma = 0; md = 0;
    rd_o = 0; wr_o = 0; wr_wd = 0; rd_sz = 0; wr_sz = 0; rd_ad = 0; wr_ad = 0; wr_dt = 0; wr_st = 0;
    ar_have = 0; aw_have = 0; w_have = 0; b_pend = 0; r_cnt = 0; b_cnt = 0;
    r_dat = 0; w_d = 0; w_s = 0; aw_wd = 0; p_ar = 0; p_w = 0; p_araddr = 0; p_wd = 0; p_ws = 0;
    done = 0; idle = 0; cyc = 0; dir_i = 0;

    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(!m_arvalid && !m_awvalid && !m_wvalid, "R9 valids in reset", {m_arvalid, m_awvalid, m_wvalid}, 0);
    chk(!cpu_data_ok && !cpu_addr_ok, "R9 handshakes in reset", {cpu_data_ok, cpu_addr_ok}, 0);
    @(negedge clk); rst_n = 1'b1;

    while (done < 800 && cyc < 40000) begin
      @(negedge clk);
      cyc++;
      prq  = (done < 400) ? 90 : 50;
      prdy = (done < 200) ? 100 : 40;
      if (!mv) begin
        if (dir_i < 6) begin
          mv = 1;
          case (dir_i)
            0: begin mw = 1; ms = 2; ma = 32'h8000_0004; md = 32'hA1B2C3D4; end
            1: begin mw = 0; ms = 2; ma = 32'h8000_0004; md = 0; end
            2: begin mw = 1; ms = 0; ma = 32'h8000_0007; md = 32'h5A00_0000; end
            3: begin mw = 0; ms = 1; ma = 32'h8000_0006; md = 0; end
            4: begin mw = 1; ms = 1; ma = 32'h8000_0008; md = 32'h0000_BEEF; end
            default: begin mw = 0; ms = 0; ma = 32'h8000_0009; md = 0; end
          endcase
          dir_i++;
        end else if ($urandom_range(99) < prq) begin
          mv = 1;
          mw = $urandom_range(1);
          ms = 2'($urandom_range(2));
          ma = 32'h8000_0000 | (32'($urandom_range(7)) << 2);
          if (ms == 2'd1) ma[1] = 1'($urandom_range(1));
          if (ms == 2'd0) ma[1:0] = 2'($urandom_range(3));
          md = $urandom;
        end
      end
      cpu_req = mv; cpu_wr = mw; cpu_size = ms; cpu_addr = ma;
      cpu_wdata = mv ? md : $urandom;

      m_arready = !ar_have && ($urandom_range(99) < prdy);
      m_awready = !aw_have && !b_pend && ($urandom_range(99) < prdy);
      m_wready  = !w_have && !b_pend && ($urandom_range(99) < prdy);
      m_rvalid  = ar_have && r_cnt == 0;
      m_rdata   = m_rvalid ? r_dat : $urandom;
      m_rlast   = 1'b1;
      m_bvalid  = b_pend && b_cnt == 0;
      #1;

      if (cpu_req)
        chk(cpu_addr_ok == (cpu_wr ? (!wr_o && !rd_o) : !rd_o), cpu_wr ? "R3 write accept" : "R4 read accept",
            cpu_addr_ok, cpu_wr ? (!wr_o && !rd_o) : !rd_o);
      else
        chk(!cpu_addr_ok, "R4 no accept without request", cpu_addr_ok, 0);

      if (p_ar) chk(m_arvalid && m_araddr == p_araddr, "R8 AR hold", m_araddr, p_araddr);
      if (p_w)  chk(m_wvalid && m_wdata == p_wd && m_wstrb == p_ws, "R8 W hold", m_wdata, p_wd);
      p_ar = m_arvalid && !m_arready; p_araddr = m_araddr;
      p_w  = m_wvalid && !m_wready;   p_wd = m_wdata; p_ws = m_wstrb;

      if (m_arvalid) chk(!(wr_o && m_araddr[4:2] == wr_wd), "R7 read held behind same-word write", m_araddr, wr_ad);

      if (m_arvalid && m_arready) begin
        chk(m_araddr == rd_ad && m_arlen == 0 && m_arsize == {1'b0, rd_sz}, "R1 AR fields",
            {m_arlen, 5'd0, m_arsize, m_araddr[15:0]}, {8'd0, 5'd0, 1'b0, rd_sz, rd_ad[15:0]});
        ar_have = 1; r_dat = smem[m_araddr[4:2]]; r_cnt = $urandom_range(3);
      end
      if (m_awvalid && m_awready) begin
        chk(m_awaddr == wr_ad && m_awlen == 0 && m_awsize == {1'b0, wr_sz}, "R1 AW fields",
            {m_awlen, 5'd0, m_awsize, m_awaddr[15:0]}, {8'd0, 5'd0, 1'b0, wr_sz, wr_ad[15:0]});
        aw_have = 1; aw_wd = m_awaddr[4:2];
      end
      if (m_wvalid && m_wready) begin
        chk(m_wstrb == wr_st, "R2 strobe", m_wstrb, wr_st);
        chk((m_wdata & lanes(wr_st)) == (wr_dt & lanes(wr_st)), "R3 captured write data", m_wdata, wr_dt);
        chk(m_wlast, "R1 single W beat", m_wlast, 1);
        w_have = 1; w_d = m_wdata; w_s = m_wstrb;
      end

      if (cpu_data_ok) begin
        idle = 0;
        if (qh == qt) chk(0, "R6 completion with nothing open", 1, 0);
        else begin
          if (q_wr[qh % 4]) chk(m_bvalid && m_bready, "R5 completion order (write first)", m_bvalid, 1);
          else begin
            chk(m_rvalid && m_rready, "R5 completion order (read)", m_rvalid, 1);
            chk((cpu_rdata & lanes(q_msk[qh % 4])) == (q_dat[qh % 4] & lanes(q_msk[qh % 4])),
                "R6 read data", cpu_rdata, q_dat[qh % 4]);
          end
          qh++; done++;
        end
      end
      if (m_bvalid) chk(m_bready, "R6 bready high", m_bready, 1);
      if ((m_bvalid && m_bready) || (m_rvalid && m_rready && m_rlast))
        chk(cpu_data_ok, "R6 data_ok on AXI completion", cpu_data_ok, 1);

      if (m_rvalid && m_rready) begin ar_have = 0; rd_o = 0; end
      if (m_bvalid && m_bready) begin b_pend = 0; wr_o = 0; end

      if (cpu_addr_ok) begin
        if (cpu_wr) begin
          wr_o = 1; wr_wd = cpu_addr[4:2]; wr_ad = cpu_addr; wr_sz = cpu_size;
          wr_st = strb_of(cpu_size, cpu_addr[1:0]); wr_dt = cpu_wdata;
          refm[cpu_addr[4:2]] = (refm[cpu_addr[4:2]] & ~lanes(wr_st)) | (cpu_wdata & lanes(wr_st));
          q_wr[qt % 4] = 1; q_dat[qt % 4] = 0; q_msk[qt % 4] = 0;
        end else begin
          rd_o = 1; rd_ad = cpu_addr; rd_sz = cpu_size;
          q_wr[qt % 4] = 0; q_dat[qt % 4] = refm[cpu_addr[4:2]];
          q_msk[qt % 4] = strb_of(cpu_size, cpu_addr[1:0]);
        end
        qt++; mv = 0;
      end

      if (aw_have && w_have && !b_pend) begin
        smem[aw_wd] = (smem[aw_wd] & ~lanes(w_s)) | (w_d & lanes(w_s));
        aw_have = 0; w_have = 0; b_pend = 1; b_cnt = $urandom_range(3);
      end else if (b_pend && b_cnt > 0) b_cnt--;
      if (ar_have && r_cnt > 0 && !(m_arvalid && m_arready)) r_cnt--;

      if (qh != qt) idle++;
      if (idle > 500) begin
        chk(0, "R5 watchdog: completion stalled", idle, 0);
        break;
      end
    end
    if (done < 800) chk(0, "R6 not all requests completed", done, 800);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule